// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block brings a microcontroller-class core out of reset. The vector table holds 32-bit pointers, not branch instructions. The sequencer reads the initial stack pointer from the first table word over a single-word read port. It then reads the reset handler address from the second word, hands both values to the core, and only then raises the run strobe. Every read holds its request until the memory acknowledges it, so any number of wait states is tolerated.

A bus error reported on either reset read stops the boot. The block then raises a lockup flag and keeps the core halted until the next reset.

Outside the boot sequence, the block keeps a writable table-base register and turns an exception number into the byte address of that exception's table entry. Software can move the table at run time, and later lookups follow the new base. A reset at any point abandons the current read, returns the base to zero and starts again from the stack-pointer read.

Top module: `vfs_boot_seq`

## Requirements
- R1: After reset, `mem_req` is high with `mem_addr` = 0x00000000, while `core_run`, `lockup`, `sp_load` and `pc_load` are low and `vec_addr` uses base 0.
- R2: The first read is at byte address 0. In the cycle after it is acknowledged without error, `sp_load` is high for one cycle and `sp_value` equals the read word with bits 1:0 cleared.
- R3: The second read is at byte address 4 and is issued only after the first is acknowledged. In the cycle after it is acknowledged without error, `pc_load` is high for one cycle and `pc_value` equals the read word with bit 0 cleared.
- R4: `core_run` rises in the same cycle as `pc_load` and stays high until reset. It is never high before both values have been loaded.
- R5: While `mem_ack` is low, `mem_req` stays high and `mem_addr` stays unchanged, for any number of wait cycles.
- R6: If `mem_err` is high together with `mem_ack` during either reset read, then from the next cycle `lockup` is high, `mem_req` is low, `core_run` stays low, and the faulting word is not loaded. This lasts until reset. `mem_err` is ignored when `mem_ack` is low.
- R7: A write (`base_wr_en` high) stores `base_wr_data` with bits 6:0 forced to zero, taking effect from the next cycle. The base is 0 after reset.
- R8: `vec_addr` equals base + 4 × `exc_num`, combinationally. Exception numbers 2 to 6 select the NMI, HardFault, MemManage, BusFault and UsageFault entries.
- R9: Asserting reset in the middle of the sequence drops the pending read. After release, the stack-pointer read at address 0 restarts and the base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data and error are valid with it |
| mem_rdata | input | 32 | Read word |
| mem_err | input | 1 | Bus error flag qualified by `mem_ack` |
| base_wr_en | input | 1 | Table-base write strobe |
| base_wr_data | input | 32 | New table base (bits 6:0 ignored) |
| exc_num | input | 9 | Exception number to look up |
| vec_addr | output | 32 | Byte address of that exception's table entry |
| sp_load | output | 1 | One-cycle strobe: load `sp_value` into the stack pointer |
| sp_value | output | 32 | Initial stack pointer, word aligned |
| pc_load | output | 1 | One-cycle strobe: load `pc_value` into the program counter |
| pc_value | output | 32 | Reset handler address with bit 0 cleared |
| core_run | output | 1 | Core may execute |
| lockup | output | 1 | Reset read faulted; core held |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high, and that `rst_n` changes away from the rising clock edge. The bench keeps to both. Its memory responder acknowledges only while its own model shows a read outstanding, with a wait count chosen per run. It changes reset and every other input on the falling edge. Error injection is applied only together with an acknowledge, and one run also drives `mem_err` alone to show that it has no effect.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned EXC_W    = 9;
  localparam int unsigned ALIGN_LO = 7;
  localparam int unsigned WORD_B   = 4;

  typedef enum logic [1:0] {
    BST_GET_SP = 2'd0,
    BST_GET_PC = 2'd1,
    BST_RUN    = 2'd2,
    BST_LOCK   = 2'd3
  } boot_st_e;
endpackage

// File: rtl/vfs_base_reg.sv
module vfs_base_reg #(
  parameter int unsigned AW    = 32,
  parameter int unsigned ALIGN = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base_q
);
  localparam logic [AW-1:0] KEEP_MASK = ~((AW'(1) << ALIGN) - AW'(1));

  logic [AW-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  AST_BASE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q == ($past(wr_data) & KEEP_MASK)); // R7
endmodule

// File: rtl/vfs_vec_addr.sv
module vfs_vec_addr #(
  parameter int unsigned AW = 32,
  parameter int unsigned EW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [EW-1:0] exc_num,
  output logic [AW-1:0] vec_addr
);
  logic [AW-1:0] offset;

  always_comb begin
    offset   = AW'(exc_num) << 2;
    vec_addr = base + offset;
  end

  AST_VEC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[1:0] == 2'b00); // R8
endmodule

// File: rtl/vfs_boot_fsm.sv
module vfs_boot_fsm
  import vfs_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SP_OFS = 0,
  parameter int unsigned PC_OFS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_err,
  output logic          sp_load,
  output logic [AW-1:0] sp_value,
  output logic          pc_load,
  output logic [AW-1:0] pc_value,
  output logic          core_run,
  output logic          lockup
);
  localparam logic [AW-1:0] SP_MASK = ~AW'(3);
  localparam logic [AW-1:0] PC_MASK = ~AW'(1);

  boot_st_e      st_q, st_d;
  logic          sp_cap, pc_cap;
  logic          sp_load_q, pc_load_q;
  logic [AW-1:0] sp_q, pc_q;

  always_comb begin
    st_d   = st_q;
    sp_cap = 1'b0;
    pc_cap = 1'b0;
    case (st_q)
      BST_GET_SP: if (mem_ack) begin
        if (mem_err) st_d = BST_LOCK;
        else begin
          sp_cap = 1'b1;
          st_d   = BST_GET_PC;
        end
      end
      BST_GET_PC: if (mem_ack) begin
        if (mem_err) st_d = BST_LOCK;
        else begin
          pc_cap = 1'b1;
          st_d   = BST_RUN;
        end
      end
      default: st_d = st_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= BST_GET_SP;
      sp_load_q <= 1'b0;
      pc_load_q <= 1'b0;
      sp_q      <= '0;
      pc_q      <= '0;
    end else begin
      st_q      <= st_d;
      sp_load_q <= sp_cap;
      pc_load_q <= pc_cap;
      if (sp_cap) sp_q <= mem_rdata & SP_MASK;
      if (pc_cap) pc_q <= mem_rdata & PC_MASK;
    end
  end

  always_comb begin
    mem_req  = (st_q == BST_GET_SP) || (st_q == BST_GET_PC);
    mem_addr = (st_q == BST_GET_PC) ? AW'(PC_OFS) : AW'(SP_OFS);
    sp_load  = sp_load_q;
    pc_load  = pc_load_q;
    sp_value = sp_q;
    pc_value = pc_q;
    core_run = (st_q == BST_RUN);
    lockup   = (st_q == BST_LOCK);
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5
  AST_RUN_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_run) |-> pc_load); // R4
  AST_PC_AFTER_SP: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |-> (mem_req && mem_addr == AW'(PC_OFS))); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |=> (lockup && !core_run && !mem_req)); // R6
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |=> core_run); // R4
endmodule

// File: rtl/vfs_boot_seq.sv
module vfs_boot_seq
  import vfs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  input  logic              mem_err,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic [EXC_W-1:0]  exc_num,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              sp_load,
  output logic [ADDR_W-1:0] sp_value,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value,
  output logic              core_run,
  output logic              lockup
);
  logic [ADDR_W-1:0] base_q;

  vfs_boot_fsm #(.AW(ADDR_W), .SP_OFS(0), .PC_OFS(WORD_B)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .mem_err   (mem_err),
    .sp_load   (sp_load),
    .sp_value  (sp_value),
    .pc_load   (pc_load),
    .pc_value  (pc_value),
    .core_run  (core_run),
    .lockup    (lockup)
  );

  vfs_base_reg #(.AW(ADDR_W), .ALIGN(ALIGN_LO)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .base_q  (base_q)
  );

  vfs_vec_addr #(.AW(ADDR_W), .EW(EXC_W)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .base     (base_q),
    .exc_num  (exc_num),
    .vec_addr (vec_addr)
  );
endmodule

// File: tb/vfs_boot_seq_bench.sv
module vfs_boot_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_ack, mem_err;
  logic [31:0] mem_addr, mem_rdata;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic [8:0]  exc_num;
  logic [31:0] vec_addr, sp_value, pc_value;
  logic        sp_load, pc_load, core_run, lockup;

  always #5 clk = ~clk;

  vfs_boot_seq u_vfs_boot_seq (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data), .exc_num(exc_num),
    .vec_addr(vec_addr), .sp_load(sp_load), .sp_value(sp_value),
    .pc_load(pc_load), .pc_value(pc_value), .core_run(core_run), .lockup(lockup)
  );

  // behavioural model: 0 = want SP, 1 = want PC, 2 = running, 3 = locked
  int          m_st;
  logic [31:0] m_sp, m_pc, m_base;
  logic        m_spl, m_pcl;
  int          wcnt, wait_sp, wait_pc;
  logic        err_sp, err_pc, stray_err;
  logic [31:0] sp_word, pc_word;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  function automatic void chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endfunction

  function automatic void model_reset();
    m_st = 0; m_sp = '0; m_pc = '0; m_base = '0; m_spl = 0; m_pcl = 0; wcnt = 0;
  endfunction

  always @(posedge clk) if (rst_n) begin
    m_spl = 0; m_pcl = 0;
    if (mem_ack && m_st < 2) begin
      if (mem_err) m_st = 3;
      else if (m_st == 0) begin m_sp = mem_rdata & 32'hFFFF_FFFC; m_spl = 1; m_st = 1; end
      else begin m_pc = mem_rdata & 32'hFFFF_FFFE; m_pcl = 1; m_st = 2; end
    end
    if (base_wr_en) m_base = base_wr_data & 32'hFFFF_FF80;
  end

  // compare, then respond as memory
  always @(negedge clk) begin
    #1;
    cyc++;
    chk("R5 mem_req", {31'd0, mem_req}, {31'd0, m_st < 2});
    chk("R5 mem_addr", mem_addr, (m_st == 1) ? 32'd4 : 32'd0);
    chk("R2 sp_load", {31'd0, sp_load}, {31'd0, m_spl});
    chk("R2 sp_value", sp_value, m_sp);
    chk("R3 pc_load", {31'd0, pc_load}, {31'd0, m_pcl});
    chk("R3 pc_value", pc_value, m_pc);
    chk("R4 core_run", {31'd0, core_run}, {31'd0, m_st == 2});
    chk("R6 lockup", {31'd0, lockup}, {31'd0, m_st == 3});
    chk("R8/R7 vec_addr", vec_addr, m_base + {21'd0, exc_num, 2'b00});
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
    mem_ack = 0; mem_err = stray_err; mem_rdata = 32'hDEAD_BEEF;
    if (rst_n && m_st < 2) begin
      if (wcnt >= ((m_st == 0) ? wait_sp : wait_pc)) begin
        wcnt = 0; mem_ack = 1;
        mem_rdata = (m_st == 0) ? sp_word : pc_word;
        mem_err = (m_st == 0) ? err_sp : err_pc;
      end else wcnt++;
    end
  end

  task automatic do_reset(input int wsp, input int wpc, input logic esp, input logic epc);
    @(negedge clk);
    rst_n = 0; model_reset();
    wait_sp = wsp; wait_pc = wpc; err_sp = esp; err_pc = epc;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    #2;
    // R1: reset state at the ports
    chk("R1 mem_req", {31'd0, mem_req}, 32'd1);
    chk("R1 mem_addr", mem_addr, 32'd0);
    chk("R1 core_run", {31'd0, core_run}, 32'd0);
    chk("R1 lockup", {31'd0, lockup}, 32'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    mem_ack = 0; mem_err = 0; mem_rdata = '0; stray_err = 0;
    base_wr_en = 0; base_wr_data = '0; exc_num = '0;
    sp_word = 32'h2000_1003; pc_word = 32'h0000_0401;
    model_reset(); wait_sp = 0; wait_pc = 0; err_sp = 0; err_pc = 0;

    // zero-wait boot, then vector lookups and base moves (R7, R8)
    do_reset(0, 0, 0, 0);
    idle(5);
    for (int e = 0; e < 9; e++) begin exc_num = 9'(e); idle(1); end
    base_wr_data = 32'h1234_56FF; base_wr_en = 1; idle(1); base_wr_en = 0;
    for (int e = 2; e <= 6; e++) begin exc_num = 9'(e); idle(1); end
    exc_num = 9'd511; idle(1);
    base_wr_data = 32'hFFFF_FF80; base_wr_en = 1; idle(1); base_wr_en = 0;
    exc_num = 9'd400; idle(2);

    // wait states (R5) and different words
    sp_word = 32'h8000_0FFF; pc_word = 32'h0800_00C3;
    do_reset(3, 5, 0, 0);
    idle(15);

    // stray error without acknowledge is ignored (R6)
    stray_err = 1;
    do_reset(2, 2, 0, 0);
    idle(10);
    stray_err = 0;

    // bus error on SP read, then on PC read (R6)
    do_reset(1, 0, 1, 0);
    idle(8);
    do_reset(0, 2, 0, 1);
    idle(8);

    // R9: base moved, reset during PC wait, restart at address 0 with base 0
    do_reset(0, 6, 0, 0);
    base_wr_data = 32'h4000_0000; base_wr_en = 1; idle(1); base_wr_en = 0;
    exc_num = 9'd3; idle(3);
    do_reset(1, 1, 0, 0);
    chk("R9 restart addr", mem_addr, 32'd0);
    chk("R9 base cleared", vec_addr, 32'd12);
    idle(8);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule